// File: doc/BRIEF.md
# Flash Region Access Permission Checker

This block decides, for each request aimed at the shared SPI flash, whether it may proceed. A request names the issuing master (host CPU, management engine or network controller), the requestor ID it presents, a linear flash address, a read or write direction and the SPI opcode it wants to run. The block finds the flash region that holds the address, then looks up that master's read and write rights for the region. It also checks the requestor ID and screens the opcode against a short list of forbidden opcodes. It returns grant or block, together with a reason code.

The region bounds, the per-master permission words and the forbidden-opcode list come from a separate loader as static configuration inputs. An external write-protect input can veto any write. A request is captured on its strobe. The verdict appears one cycle later and is computed combinationally from the captured request and the live configuration.

Top module: `flash_access_guard`

## Requirements
- R1: While reset is asserted and after it is released, and before any request is strobed, `rsp_valid` and `rsp_grant` are 0.
- R2: Region n (0 to 4) has a 13-bit base in `cfg_rgn_base[13n+12:13n]` and a 13-bit limit in `cfg_rgn_limit[13n+12:13n]`, both in 4 KiB pages. An address is inside region n when its bits 24:12 are at least the base and at most the limit. The limit is inclusive.
- R3: A region whose base is greater than its limit is inactive and matches no address. The disable code is base 1FFFh with limit 0000h.
- R4: When several active regions hold the address, the one with the lowest index decides the permission lookup.
- R5: An address that lies in no active region is blocked with reason 4.
- R6: The permission word of master m is `cfg_perm[32m+31:32m]`. Its bits 28:24 are the write map and its bits 20:16 are the read map, with bit n of each map meaning region n. A request without the matching bit is blocked with reason 5.
- R7: A master may always read and write its own region, whatever its map bits say. Master 0 (host) owns region 1, master 1 (engine) owns region 2 and master 2 (network controller) owns region 3.
- R8: The requestor ID must equal bits 15:0 of the master's permission word. It must also equal the platform ID, which is 0000h for masters 0 and 1, and 0218h for master 2, or 0118h when `nic_id_alt` is 1. A mismatch is blocked with reason 2. Master index 3 is blocked with reason 1.
- R9: `cfg_op_block` holds four 8-bit opcodes, entry k in bits 8k+7:8k. A request whose opcode equals a nonzero entry is blocked with reason 3. Entries of 00h forbid nothing.
- R10: When `bios_wp` is 1, a write that passes every other check is blocked with reason 6. Reads are unaffected.
- R11: A request sampled with `req_valid` high gives `rsp_valid` high on the next cycle, for that cycle only. `rsp_grant` is 1 only in such a cycle, and only when the reason is 0.
- R12: Reason codes are 0 grant, 1 bad master, 2 bad ID, 3 forbidden opcode, 4 no region, 5 no permission and 6 write-protected. When several checks fail, the lowest nonzero code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rgn_base | input | 65 | Five 13-bit region bases, in pages |
| cfg_rgn_limit | input | 65 | Five 13-bit inclusive region limits, in pages |
| cfg_perm | input | 96 | Three 32-bit per-master permission words |
| cfg_op_block | input | 32 | Four forbidden opcodes; 00h entries are unused |
| nic_id_alt | input | 1 | Selects the alternate network controller ID 0118h |
| bios_wp | input | 1 | External write protect |
| req_valid | input | 1 | Request strobe |
| req_master | input | 2 | Master index |
| req_rid | input | 16 | Presented requestor ID |
| req_addr | input | 25 | Linear flash address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_opcode | input | 8 | SPI opcode |
| rsp_valid | output | 1 | Verdict valid, one cycle after the strobe |
| rsp_grant | output | 1 | Request allowed |
| rsp_reason | output | 3 | Reason code |

## Verification
The assertions check on every cycle that the response follows a strobe by exactly one cycle and does not outlive it. They also check that a grant never coexists with a failed ID check, a forbidden opcode, a missing region or a protected write. Only the bench's scenarios can show that the right region is selected at the page bounds and under overlap, and that the own-region exception and the alternate network controller ID take effect. The same holds for the reason ordering when several checks fail at once. A seeded random sweep over configurations and requests, compared against a bench model, covers the interactions between these checks.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    RSN_GRANT      = 3'd0,
    RSN_BAD_MASTER = 3'd1,
    RSN_BAD_ID     = 3'd2,
    RSN_OPCODE     = 3'd3,
    RSN_NO_REGION  = 3'd4,
    RSN_NO_PERM    = 3'd5,
    RSN_WPROT      = 3'd6
  } reason_e;

  localparam int unsigned PERM_W      = 32;
  localparam int unsigned PERM_WR_LSB = 24;
  localparam int unsigned PERM_RD_LSB = 16;
  localparam int unsigned RID_W       = 16;

endpackage

// File: rtl/flash_region_match.sv
module flash_region_match #(
  parameter int unsigned NUM_RGN = 5,
  parameter int unsigned PAGE_W  = 13,
  parameter int unsigned ADDR_W  = 25,
  localparam int unsigned IDX_W   = $clog2(NUM_RGN),
  localparam int unsigned PAGE_LSB = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_RGN*PAGE_W-1:0] base_flat,
  input  logic [NUM_RGN*PAGE_W-1:0] limit_flat,
  output logic                      any_hit,
  output logic [IDX_W-1:0]          hit_idx
);

  logic [PAGE_W-1:0]  page;
  logic [NUM_RGN-1:0] raw_hit;

  assign page = addr[ADDR_W-1:PAGE_LSB];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [PAGE_W-1:0] lo, hi;
    assign lo = base_flat[g*PAGE_W +: PAGE_W];
    assign hi = limit_flat[g*PAGE_W +: PAGE_W];
    assign raw_hit[g] = (lo <= hi) && (page >= lo) && (page <= hi);
  end

  // lowest matching index wins
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_RGN - 1; i >= 0; i--) begin
      if (raw_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |raw_hit;

endmodule

// File: rtl/flash_opcode_filter.sv
module flash_opcode_filter #(
  parameter int unsigned NUM_OPS = 4,
  parameter int unsigned OP_W    = 8
) (
  input  logic [NUM_OPS*OP_W-1:0] op_list,
  input  logic [OP_W-1:0]         opcode,
  output logic                    op_hit
);

  logic [NUM_OPS-1:0] ent_hit;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_ent
    logic [OP_W-1:0] ent;
    assign ent = op_list[g*OP_W +: OP_W];
    assign ent_hit[g] = (ent != '0) && (ent == opcode);
  end

  assign op_hit = |ent_hit;

endmodule

// File: rtl/flash_perm_check.sv
module flash_perm_check
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_MST    = 3,
  parameter int unsigned NUM_RGN    = 5,
  parameter int unsigned NIC_MASTER = 2,
  parameter logic [RID_W-1:0] NIC_ID_DEF = 16'h0218,
  parameter logic [RID_W-1:0] NIC_ID_ALT = 16'h0118,
  localparam int unsigned MST_W     = $clog2(NUM_MST + 1),
  localparam int unsigned IDX_W     = $clog2(NUM_RGN),
  localparam int unsigned MST_SLOTS = 1 << MST_W,
  localparam int unsigned RGN_SLOTS = 1 << IDX_W
) (
  input  logic [NUM_MST*PERM_W-1:0] perm_flat,
  input  logic [MST_W-1:0]          master,
  input  logic [RID_W-1:0]          rid,
  input  logic                      write,
  input  logic [IDX_W-1:0]          rgn_idx,
  input  logic                      nic_alt,
  output logic                      master_ok,
  output logic                      id_ok,
  output logic                      perm_ok
);

  logic [PERM_W-1:0]    word_a [MST_SLOTS];
  logic [PERM_W-1:0]    word;
  logic [RID_W-1:0]     plat_id;
  logic [RGN_SLOTS-1:0] wr_map, rd_map;
  logic [IDX_W-1:0]     own_idx;

  for (genvar g = 0; g < MST_SLOTS; g++) begin : g_word
    if (g < NUM_MST) begin : g_real
      assign word_a[g] = perm_flat[g*PERM_W +: PERM_W];
    end else begin : g_none
      assign word_a[g] = '0;
    end
  end

  assign master_ok = (int'(master) < NUM_MST);
  assign word      = word_a[master];

  assign plat_id = (int'(master) == NIC_MASTER) ? (nic_alt ? NIC_ID_ALT : NIC_ID_DEF)
                                                : '0;
  assign id_ok   = (rid == word[RID_W-1:0]) && (rid == plat_id);

  assign wr_map  = RGN_SLOTS'(word[PERM_WR_LSB +: NUM_RGN]);
  assign rd_map  = RGN_SLOTS'(word[PERM_RD_LSB +: NUM_RGN]);
  // master m owns region m+1
  assign own_idx = IDX_W'(master) + IDX_W'(1);
  assign perm_ok = (rgn_idx == own_idx) || (write ? wr_map[rgn_idx] : rd_map[rgn_idx]);

endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_RGN = 5,
  parameter int unsigned NUM_MST = 3,
  parameter int unsigned NUM_OPS = 4,
  parameter int unsigned OP_W    = 8,
  parameter int unsigned PAGE_W  = 13,
  parameter int unsigned ADDR_W  = 25,
  localparam int unsigned MST_W  = $clog2(NUM_MST + 1),
  localparam int unsigned IDX_W  = $clog2(NUM_RGN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_RGN*PAGE_W-1:0] cfg_rgn_base,
  input  logic [NUM_RGN*PAGE_W-1:0] cfg_rgn_limit,
  input  logic [NUM_MST*PERM_W-1:0] cfg_perm,
  input  logic [NUM_OPS*OP_W-1:0]   cfg_op_block,
  input  logic                      nic_id_alt,
  input  logic                      bios_wp,
  input  logic                      req_valid,
  input  logic [MST_W-1:0]          req_master,
  input  logic [RID_W-1:0]          req_rid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic [OP_W-1:0]           req_opcode,
  output logic                      rsp_valid,
  output logic                      rsp_grant,
  output logic [2:0]                rsp_reason
);

  // captured request
  logic [MST_W-1:0]  q_master, d_master;
  logic [RID_W-1:0]  q_rid, d_rid;
  logic [ADDR_W-1:0] q_addr, d_addr;
  logic              q_write, d_write;
  logic [OP_W-1:0]   q_op, d_op;
  logic              q_valid, d_valid;

  always_comb begin
    d_master = q_master;
    d_rid    = q_rid;
    d_addr   = q_addr;
    d_write  = q_write;
    d_op     = q_op;
    d_valid  = req_valid;
    if (req_valid) begin
      d_master = req_master;
      d_rid    = req_rid;
      d_addr   = req_addr;
      d_write  = req_write;
      d_op     = req_opcode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_master <= '0;
      q_rid    <= '0;
      q_addr   <= '0;
      q_write  <= 1'b0;
      q_op     <= '0;
      q_valid  <= 1'b0;
    end else begin
      q_master <= d_master;
      q_rid    <= d_rid;
      q_addr   <= d_addr;
      q_write  <= d_write;
      q_op     <= d_op;
      q_valid  <= d_valid;
    end
  end

  logic             rgn_any;
  logic [IDX_W-1:0] rgn_idx;
  logic             op_hit;
  logic             master_ok, id_ok, perm_ok;
  reason_e          reason;

  flash_region_match #(
    .NUM_RGN (NUM_RGN),
    .PAGE_W  (PAGE_W),
    .ADDR_W  (ADDR_W)
  ) u_rgn (
    .addr       (q_addr),
    .base_flat  (cfg_rgn_base),
    .limit_flat (cfg_rgn_limit),
    .any_hit    (rgn_any),
    .hit_idx    (rgn_idx)
  );

  flash_opcode_filter #(
    .NUM_OPS (NUM_OPS),
    .OP_W    (OP_W)
  ) u_op (
    .op_list (cfg_op_block),
    .opcode  (q_op),
    .op_hit  (op_hit)
  );

  flash_perm_check #(
    .NUM_MST (NUM_MST),
    .NUM_RGN (NUM_RGN)
  ) u_perm (
    .perm_flat (cfg_perm),
    .master    (q_master),
    .rid       (q_rid),
    .write     (q_write),
    .rgn_idx   (rgn_idx),
    .nic_alt   (nic_id_alt),
    .master_ok (master_ok),
    .id_ok     (id_ok),
    .perm_ok   (perm_ok)
  );

  // verdict, first failing check reported
  always_comb begin
    if (!master_ok)              reason = RSN_BAD_MASTER;
    else if (!id_ok)             reason = RSN_BAD_ID;
    else if (op_hit)             reason = RSN_OPCODE;
    else if (!rgn_any)           reason = RSN_NO_REGION;
    else if (!perm_ok)           reason = RSN_NO_PERM;
    else if (q_write && bios_wp) reason = RSN_WPROT;
    else                         reason = RSN_GRANT;
  end

  assign rsp_valid  = q_valid;
  assign rsp_reason = reason;
  assign rsp_grant  = q_valid && (reason == RSN_GRANT);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_grant); // R11
  AST_ID_GATES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> master_ok && id_ok); // R8
  AST_OPCODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && op_hit |-> !rsp_grant); // R9
  AST_NO_REGION_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rgn_any |-> !rsp_grant); // R5
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && q_write && bios_wp |-> !rsp_grant); // R10

endmodule

// File: tb/flash_access_guard_tb_top.sv
`timescale 1ns/1ps
module flash_access_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [64:0] cfg_rgn_base, cfg_rgn_limit;
  logic [95:0] cfg_perm;
  logic [31:0] cfg_op_block;
  logic        nic_id_alt, bios_wp;
  logic        req_valid, req_write;
  logic [1:0]  req_master;
  logic [15:0] req_rid;
  logic [24:0] req_addr;
  logic [7:0]  req_opcode;
  logic        rsp_valid, rsp_grant;
  logic [2:0]  rsp_reason;

  logic [12:0] cb [5];
  logic [12:0] cl [5];
  logic [31:0] cp [3];
  logic [7:0]  cbl [4];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int r = 0; r < 5; r++) begin
      cfg_rgn_base[r*13 +: 13]  = cb[r];
      cfg_rgn_limit[r*13 +: 13] = cl[r];
    end
    for (int m = 0; m < 3; m++) cfg_perm[m*32 +: 32] = cp[m];
    for (int k = 0; k < 4; k++) cfg_op_block[k*8 +: 8] = cbl[k];
  end

  flash_access_guard dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_rgn_base(cfg_rgn_base), .cfg_rgn_limit(cfg_rgn_limit),
    .cfg_perm(cfg_perm), .cfg_op_block(cfg_op_block),
    .nic_id_alt(nic_id_alt), .bios_wp(bios_wp),
    .req_valid(req_valid), .req_master(req_master), .req_rid(req_rid),
    .req_addr(req_addr), .req_write(req_write), .req_opcode(req_opcode),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason)
  );

  function automatic logic [31:0] mk_perm(logic [4:0] wr, logic [4:0] rd, logic [15:0] rid);
    return {3'b000, wr, 3'b000, rd, rid};
  endfunction

  // expected reason, from the requirements
  function automatic logic [2:0] model(logic [1:0] m, logic [15:0] rid, logic [24:0] a,
                                       logic wr, logic [7:0] op);
    logic [31:0] w;
    logic [15:0] pid;
    logic [12:0] pg;
    int hit;
    bit ok;
    if (m == 2'd3) return 3'd1;
    w   = cp[m];
    pid = (m == 2'd2) ? (nic_id_alt ? 16'h0118 : 16'h0218) : 16'h0000;
    if (rid != w[15:0] || rid != pid) return 3'd2;
    for (int k = 0; k < 4; k++) if (cbl[k] != 8'h00 && cbl[k] == op) return 3'd3;
    pg  = a[24:12];
    hit = -1;
    for (int r = 4; r >= 0; r--)
      if (cb[r] <= cl[r] && pg >= cb[r] && pg <= cl[r]) hit = r;
    if (hit < 0) return 3'd4;
    ok = (hit == int'(m) + 1) || (wr ? w[24 + hit] : w[16 + hit]);
    if (!ok) return 3'd5;
    if (wr && bios_wp) return 3'd6;
    return 3'd0;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, response sampled at the following negedge
  task automatic send(logic [1:0] m, logic [15:0] rid, logic [12:0] pg, logic wr,
                      logic [7:0] op, string req);
    logic [2:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_master = m; req_rid = rid;
    req_addr = {pg, 12'h5A4}; req_write = wr; req_opcode = op;
    exp = model(m, rid, {pg, 12'h5A4}, wr, op);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " valid"}, rsp_valid, 1);
    check(rsp_reason == exp && rsp_grant == (exp == 3'd0), req,
          {rsp_grant, rsp_reason}, {(exp == 3'd0), exp});
  endtask

  task automatic send_exp(logic [1:0] m, logic [15:0] rid, logic [12:0] pg, logic wr,
                          logic [7:0] op, logic [2:0] exp, string req);
    @(negedge clk);
    req_valid = 1'b1; req_master = m; req_rid = rid;
    req_addr = {pg, 12'h000}; req_write = wr; req_opcode = op;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_reason == exp && rsp_grant == (exp == 3'd0), req,
          {rsp_valid, rsp_grant, rsp_reason}, {1'b1, (exp == 3'd0), exp});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_master = '0; req_rid = '0;
    req_addr = '0; req_write = 1'b0; req_opcode = '0;
    nic_id_alt = 1'b0; bios_wp = 1'b0;
    cb[0] = 13'h0000; cl[0] = 13'h0000;
    cb[1] = 13'h0001; cl[1] = 13'h007F;
    cb[2] = 13'h0080; cl[2] = 13'h00FF;
    cb[3] = 13'h0100; cl[3] = 13'h010F;
    cb[4] = 13'h1FFF; cl[4] = 13'h0000;
    cp[0] = mk_perm(5'b00000, 5'b00001, 16'h0000);
    cp[1] = mk_perm(5'b00000, 5'b00000, 16'h0000);
    cp[2] = mk_perm(5'b00000, 5'b00000, 16'h0218);
    cbl[0] = 8'hC7; cbl[1] = 8'h00; cbl[2] = 8'h00; cbl[3] = 8'h00;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0 && rsp_grant == 0, "R1 in reset", {rsp_valid, rsp_grant}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rsp_valid == 0 && rsp_grant == 0, "R1 after reset", {rsp_valid, rsp_grant}, 0);

    send_exp(2'd0, 16'h0000, 13'h0000, 1'b0, 8'h03, 3'd0, "R6 host read map bit0");
    send_exp(2'd0, 16'h0000, 13'h0000, 1'b1, 8'h02, 3'd5, "R6 host write map bit0 clear");
    send_exp(2'd0, 16'h0000, 13'h007F, 1'b1, 8'h02, 3'd0, "R7 host writes own, R2 limit inclusive");
    send_exp(2'd0, 16'h0000, 13'h0080, 1'b0, 8'h03, 3'd5, "R2 base of region 2");
    send_exp(2'd1, 16'h0000, 13'h0080, 1'b1, 8'h02, 3'd0, "R7 engine writes own region");
    send_exp(2'd2, 16'h0218, 13'h010F, 1'b0, 8'h03, 3'd0, "R7 nic reads own region");
    send_exp(2'd2, 16'h0218, 13'h0110, 1'b0, 8'h03, 3'd4, "R5 page past every limit");
    send_exp(2'd2, 16'h0218, 13'h1FFF, 1'b0, 8'h03, 3'd4, "R3 disabled region 4");
    // R11: response lasts a single cycle
    @(negedge clk);
    check(rsp_valid == 0 && rsp_grant == 0, "R11 response one cycle", {rsp_valid, rsp_grant}, 0);

    nic_id_alt = 1'b1;
    send_exp(2'd2, 16'h0218, 13'h0100, 1'b0, 8'h03, 3'd2, "R8 default nic id with alt mode");
    cp[2] = mk_perm(5'b00000, 5'b00000, 16'h0118);
    send_exp(2'd2, 16'h0118, 13'h0100, 1'b0, 8'h03, 3'd0, "R8 alternate nic id");
    send_exp(2'd0, 16'h0001, 13'h0000, 1'b0, 8'h03, 3'd2, "R8 host id mismatch");
    send_exp(2'd3, 16'h0000, 13'h0000, 1'b0, 8'h03, 3'd1, "R8 master index 3");

    send_exp(2'd0, 16'h0000, 13'h0010, 1'b1, 8'hC7, 3'd3, "R9 listed opcode");
    send_exp(2'd0, 16'h0000, 13'h0010, 1'b0, 8'h00, 3'd0, "R9 zero entries forbid nothing");

    bios_wp = 1'b1;
    send_exp(2'd0, 16'h0000, 13'h0010, 1'b1, 8'h02, 3'd6, "R10 write protected");
    send_exp(2'd0, 16'h0000, 13'h0010, 1'b0, 8'h03, 3'd0, "R10 read unaffected");
    send_exp(2'd0, 16'h0000, 13'h1FFF, 1'b1, 8'h02, 3'd4, "R12 no region before write protect");
    send_exp(2'd0, 16'h0001, 13'h1FFF, 1'b1, 8'hC7, 3'd2, "R12 bad id first");
    send_exp(2'd0, 16'h0000, 13'h1FFF, 1'b1, 8'hC7, 3'd3, "R12 opcode before no region");
    bios_wp = 1'b0;

    cb[2] = 13'h0050;
    send_exp(2'd1, 16'h0000, 13'h0060, 1'b0, 8'h03, 3'd5, "R4 overlap, region 1 wins");
    send_exp(2'd1, 16'h0000, 13'h00A0, 1'b0, 8'h03, 3'd0, "R4 region 2 alone");

    for (int i = 0; i < 400; i++) begin
      logic [1:0]  m;
      logic [15:0] rid;
      logic [7:0]  ops [6];
      ops[0] = 8'h00; ops[1] = 8'hC7; ops[2] = 8'h03;
      ops[3] = 8'h02; ops[4] = 8'hD8; ops[5] = 8'h60;
      for (int r = 0; r < 5; r++) begin
        if ($urandom % 6 == 0) begin
          cb[r] = 13'h1FFF; cl[r] = 13'h0000;
        end else begin
          cb[r] = 13'($urandom % 64);
          cl[r] = cb[r] + 13'($urandom % 32);
        end
      end
      nic_id_alt = 1'($urandom);
      bios_wp    = ($urandom % 3 == 0);
      for (int mm = 0; mm < 3; mm++)
        cp[mm] = {$urandom, 16'h0} |
                 ((mm == 2) ? (nic_id_alt ? 32'h0118 : 32'h0218) : 32'h0);
      for (int k = 0; k < 4; k++) cbl[k] = ($urandom % 2) ? ops[$urandom % 6] : 8'h00;
      m   = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      rid = ($urandom % 5 == 0) ? 16'($urandom) : cp[(m == 2'd3) ? 0 : m][15:0];
      send(m, rid, 13'($urandom % 100), 1'($urandom), ops[$urandom % 6], "R12 random");
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule